// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds the transmit mailboxes of a CAN controller and decides which pending frame goes to the bit-level transmitter next. Each mailbox stores an identifier word, a 4-bit length code and eight data bytes. Software loads a mailbox through a small register port and arms it by writing the identifier word with its request bit set. When the transmitter is idle, the scheduler launches the pending frame with the best bus priority. It then holds that choice until the transmitter reports the end of the attempt.

The transmitter handshake has a one-cycle `tx_start` pulse with the mailbox index and the frame contents. The transmitter answers with a one-cycle `tx_done` pulse, qualified by `tx_ok` and `tx_arb_lost`. A status word reports the following for each mailbox: completion, success, emptiness and an outstanding abort. The same word carries a suggested mailbox index for the next load. Software can abort a mailbox. A frame that has not started is cancelled at once. A frame that is already on the bus runs to the end of its attempt, and the abort is resolved by the outcome of that attempt.

Register map (word addresses):
- Mailbox N, address 4N: identifier word.
- Mailbox N, address 4N+1: length code in bits 3:0.
- Mailbox N, address 4N+2: data bytes 0 to 3.
- Mailbox N, address 4N+3: data bytes 4 to 7.
- Address 4·NUM_MB: status word.
- Address 4·NUM_MB+1: control word. Bit 0 = 1 disables automatic retransmission. Reset value is 0.

Top module: `can_txmb_sched`

## Requirements
- R1: The identifier word carries a standard ID in bits 31:21 or an extended ID in bits 31:3. Bit 2 = 1 marks an extended ID and bit 1 = 1 marks a remote frame. Writing the word with bit 0 = 1 into an empty mailbox arms it, and reading the word back then shows bit 0 = 1. The matching `mb_empty` bit drops, and the frame is offered to the transmitter with its stored fields on `tx_id`/`tx_len`/`tx_data`.
- R2: Among pending frames, the one with the lower identifier value is launched first. An extended ID is compared through its 11-bit base first and then its low 18 bits.
- R3: When two identifiers are equal, the data frame (bit 1 = 0) is launched before the remote frame.
- R4: When a standard ID and an extended ID have the same 11-bit base, the standard frame is launched first, regardless of the remote flag.
- R5: Pending frames of equal priority are launched in ascending mailbox index.
- R6: The status word sets bit 8N+2 when mailbox N is empty. Bits 25:24 (`next_code`) give the lowest empty mailbox index. When every mailbox is full, they give the lowest-priority pending mailbox, and on a priority tie the higher index.
- R7: A successful attempt clears the request bit, sets transmit-ok (status bit 8N+1) and sets request-complete (status bit 8N+0). The mailbox becomes empty.
- R8: Writing 1 to status bit 8N+7 for a pending mailbox that is not in flight cancels it in the next cycle. Request-complete is set, transmit-ok is cleared, and the frame is never launched.
- R9: An abort of the in-flight mailbox keeps bit 8N+7 at 1 until the attempt ends. Success then gives transmit-ok = 1. A failure completes the request with transmit-ok = 0 and no retry.
- R10: A failed attempt (`tx_ok` = 0 or `tx_arb_lost` = 1) is retried while retransmission is enabled. When retransmission is disabled, the failed attempt completes with transmit-ok = 0.
- R11: Writing 1 to status bit 8N+0 clears request-complete of mailbox N. Writing 0 leaves it unchanged, and so does a write that touches only that bit, which leaves transmit-ok unchanged.
- R12: Writes to the identifier, length or data registers of a pending mailbox are ignored.
- R13: Priority is re-evaluated only between frames. A better frame armed while another is in flight waits for that attempt to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| tx_start | output | 1 | One-cycle launch pulse to the transmitter |
| tx_mbox | output | IDX_W | Mailbox being transmitted |
| tx_id | output | 32 | Identifier word of the frame in flight (bit 0 reads 0) |
| tx_len | output | 4 | Length code of the frame in flight |
| tx_data | output | 64 | Data bytes of the frame in flight, byte 0 in bits 7:0 |
| tx_done | input | 1 | End of the current attempt |
| tx_ok | input | 1 | With `tx_done`: the frame was sent |
| tx_arb_lost | input | 1 | With `tx_done`: arbitration was lost |
| busy | output | 1 | A frame is in flight |
| mb_empty | output | NUM_MB | Empty flag per mailbox |
| next_code | output | IDX_W | Suggested mailbox index, as in R6 |

## Verification
A wrong priority key or a wrong tie-break shows up as the wrong `tx_mbox` at the very next launch. The scenarios therefore keep one frame in flight while the others are armed, then make it fail, so that all three mailboxes compete in a single choice. Mistakes in the request, abort or completion flags show up in the status word read one cycle after the event that should change them. A lost retry, or a frame that should have been cancelled, shows up as a missing or extra `tx_start` within ten cycles. `next_code` is compared whenever all mailboxes are full, which is the case where it must name the lowest-priority frame.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
    localparam int KEY_W = 31;
    typedef logic [KEY_W-1:0] prio_key_t;

    // Lower key value = higher bus priority: base ID, then standard before
    // extended, then extended low bits, then data before remote.
    function automatic prio_key_t prio_key(input logic [31:0] idw);
        logic ext;
        ext = idw[2];
        return {idw[31:21], ext, (ext ? idw[20:3] : 18'd0), idw[1]};
    endfunction
endpackage

// File: rtl/txsched_mbox.sv
module txsched_mbox (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_id,
    input  logic        wr_len,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [31:1] id_o,
    output logic [3:0]  len_o,
    output logic [63:0] data_o
);
    typedef struct packed {
        logic [31:1] id;
        logic [3:0]  len;
        logic [63:0] data;
    } mb_t;

    mb_t mb_d, mb_q;

    always_comb begin
        mb_d = mb_q;
        if (wr_id)  mb_d.id           = wdata[31:1];
        if (wr_len) mb_d.len          = wdata[3:0];
        if (wr_lo)  mb_d.data[31:0]   = wdata;
        if (wr_hi)  mb_d.data[63:32]  = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mb_q <= '0;
        else        mb_q <= mb_d;
    end

    assign id_o   = mb_q.id;
    assign len_o  = mb_q.len;
    assign data_o = mb_q.data;
endmodule

// File: rtl/txsched_pick.sv
module txsched_pick import txsched_pkg::*; #(
    parameter  int NUM   = 3,
    localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   valid_i,
    input  prio_key_t        key_i [NUM],
    output logic             any_o,
    output logic [IDX_W-1:0] best_o,
    output logic [IDX_W-1:0] worst_o
);
    // Strict compare keeps the lower index on ties for best,
    // non-strict compare keeps the higher index on ties for worst.
    always_comb begin
        any_o   = 1'b0;
        best_o  = '0;
        worst_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (valid_i[i]) begin
                if (!any_o || key_i[i] <  key_i[best_o])  best_o  = IDX_W'(i);
                if (!any_o || key_i[i] >= key_i[worst_o]) worst_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end

    // R1
    best_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> valid_i[best_o]);

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        // R2
        best_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i[g] |-> (key_i[best_o] <= key_i[g]));
    end
endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched import txsched_pkg::*; #(
    parameter  int NUM_MB = 3,
    localparam int IDX_W  = $clog2(NUM_MB),
    localparam int ADDR_W = $clog2(4*NUM_MB+2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_start,
    output logic [IDX_W-1:0]  tx_mbox,
    output logic [31:0]       tx_id,
    output logic [3:0]        tx_len,
    output logic [63:0]       tx_data,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic              tx_arb_lost,
    output logic              busy,
    output logic [NUM_MB-1:0] mb_empty,
    output logic [IDX_W-1:0]  next_code
);
    // Status layout packs 8 bits per mailbox plus the code field: NUM_MB is 2 or 3.
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(4*NUM_MB);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(4*NUM_MB+1);

    typedef struct packed {
        logic [NUM_MB-1:0] txrq;
        logic [NUM_MB-1:0] rqcp;
        logic [NUM_MB-1:0] txok;
        logic [NUM_MB-1:0] abrt;
        logic              busy;
        logic              start;
        logic              nart;
        logic [IDX_W-1:0]  cur;
    } st_t;

    st_t st_d, st_q;

    logic [31:1]      mb_id   [NUM_MB];
    logic [3:0]       mb_len  [NUM_MB];
    logic [63:0]      mb_data [NUM_MB];
    prio_key_t        mb_key  [NUM_MB];
    logic             any_pend;
    logic [IDX_W-1:0] best_idx, worst_idx;
    logic             launch;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        logic wr_ok;
        assign wr_ok = reg_wr && !st_q.txrq[g];
        txsched_mbox i_mbox (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_id  (wr_ok && reg_addr == ADDR_W'(4*g)),
            .wr_len (wr_ok && reg_addr == ADDR_W'(4*g+1)),
            .wr_lo  (wr_ok && reg_addr == ADDR_W'(4*g+2)),
            .wr_hi  (wr_ok && reg_addr == ADDR_W'(4*g+3)),
            .wdata  (reg_wdata),
            .id_o   (mb_id[g]),
            .len_o  (mb_len[g]),
            .data_o (mb_data[g])
        );
        assign mb_key[g] = prio_key({mb_id[g], 1'b0});
    end

    txsched_pick #(.NUM(NUM_MB)) i_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (st_q.txrq),
        .key_i   (mb_key),
        .any_o   (any_pend),
        .best_o  (best_idx),
        .worst_o (worst_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        launch     = !st_q.busy && any_pend;

        for (int n = 0; n < NUM_MB; n++) begin
            if (reg_wr && reg_addr == ADDR_W'(4*n) && !st_q.txrq[n] && reg_wdata[0]) begin
                st_d.txrq[n] = 1'b1;
                st_d.rqcp[n] = 1'b0;
                st_d.txok[n] = 1'b0;
            end
        end

        if (reg_wr && reg_addr == CTRL_A) st_d.nart = reg_wdata[0];

        if (reg_wr && reg_addr == STAT_A) begin
            for (int n = 0; n < NUM_MB; n++) begin
                if (reg_wdata[8*n]) st_d.rqcp[n] = 1'b0;
                if (reg_wdata[8*n+7] && st_q.txrq[n]) begin
                    if ((st_q.busy && st_q.cur == IDX_W'(n)) || (launch && best_idx == IDX_W'(n))) begin
                        st_d.abrt[n] = 1'b1;
                    end else begin
                        st_d.txrq[n] = 1'b0;
                        st_d.rqcp[n] = 1'b1;
                        st_d.txok[n] = 1'b0;
                    end
                end
            end
        end

        if (st_q.busy && tx_done) begin
            st_d.busy = 1'b0;
            if (tx_ok && !tx_arb_lost) begin
                st_d.txrq[st_q.cur] = 1'b0;
                st_d.rqcp[st_q.cur] = 1'b1;
                st_d.txok[st_q.cur] = 1'b1;
                st_d.abrt[st_q.cur] = 1'b0;
            end else if (st_q.nart || st_d.abrt[st_q.cur]) begin
                st_d.txrq[st_q.cur] = 1'b0;
                st_d.rqcp[st_q.cur] = 1'b1;
                st_d.txok[st_q.cur] = 1'b0;
                st_d.abrt[st_q.cur] = 1'b0;
            end
        end

        if (launch) begin
            st_d.busy  = 1'b1;
            st_d.cur   = best_idx;
            st_d.start = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        next_code = worst_idx;
        for (int n = NUM_MB-1; n >= 0; n--) begin
            if (!st_q.txrq[n]) next_code = IDX_W'(n);
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < NUM_MB; n++) begin
            if (reg_addr == ADDR_W'(4*n))   reg_rdata = {mb_id[n], st_q.txrq[n]};
            if (reg_addr == ADDR_W'(4*n+1)) reg_rdata = {28'd0, mb_len[n]};
            if (reg_addr == ADDR_W'(4*n+2)) reg_rdata = mb_data[n][31:0];
            if (reg_addr == ADDR_W'(4*n+3)) reg_rdata = mb_data[n][63:32];
        end
        if (reg_addr == STAT_A) begin
            for (int n = 0; n < NUM_MB; n++) begin
                reg_rdata[8*n]   = st_q.rqcp[n];
                reg_rdata[8*n+1] = st_q.txok[n];
                reg_rdata[8*n+2] = !st_q.txrq[n];
                reg_rdata[8*n+7] = st_q.abrt[n];
            end
            reg_rdata[8*NUM_MB +: IDX_W] = next_code;
        end
        if (reg_addr == CTRL_A) reg_rdata[0] = st_q.nart;
    end

    assign tx_start = st_q.start;
    assign tx_mbox  = st_q.cur;
    assign tx_id    = {mb_id[st_q.cur], 1'b0};
    assign tx_len   = mb_len[st_q.cur];
    assign tx_data  = mb_data[st_q.cur];
    assign busy     = st_q.busy;
    assign mb_empty = ~st_q.txrq;

    // R1
    start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (!mb_empty[tx_mbox] && busy));

    // R13
    cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_done) |=> (busy && $stable(tx_mbox) && !tx_start));

    // R6
    code_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|mb_empty) |-> mb_empty[next_code]);

    // R10
    retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_done && (!tx_ok || tx_arb_lost) && !st_q.nart && !st_q.abrt[st_q.cur] && !reg_wr)
        |=> !mb_empty[$past(tx_mbox)]);

    for (genvar g = 0; g < NUM_MB; g++) begin : g_chk
        // R7
        ok_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.txok[g]) |-> (st_q.rqcp[g] && mb_empty[g]));
        // R9
        abort_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.abrt[g] |-> (!mb_empty[g] && busy && tx_mbox == IDX_W'(g)));
    end
endmodule

// File: tb/test_can_txmb_sched.sv
module test_can_txmb_sched;
    localparam int NMB = 3;
    localparam logic [3:0] STAT = 4'd12;
    localparam logic [3:0] CTRL = 4'd13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_start;
    logic [1:0]  tx_mbox;
    logic [31:0] tx_id;
    logic [3:0]  tx_len;
    logic [63:0] tx_data;
    logic        tx_done = 1'b0, tx_ok = 1'b0, tx_arb_lost = 1'b0;
    logic        busy;
    logic [2:0]  mb_empty;
    logic [1:0]  next_code;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] m_id [NMB];
    bit          m_pend [NMB];

    can_txmb_sched i_can_txmb_sched (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load(int mb, logic [31:0] idw, logic [3:0] len, logic [63:0] dat);
        wr(4'(4*mb+1), {28'd0, len});
        wr(4'(4*mb+2), dat[31:0]);
        wr(4'(4*mb+3), dat[63:32]);
        wr(4'(4*mb), idw | 32'd1);
    endtask

    task automatic wait_start(string req, output int idx);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tx_start && n < 50);
        chk(req, 64'(tx_start), 64'd1);
        idx = int'(tx_mbox);
    endtask

    task automatic finish_tx(bit ok, bit arb);
        @(negedge clk);
        tx_done = 1'b1; tx_ok = ok; tx_arb_lost = arb;
        @(negedge clk);
        tx_done = 1'b0; tx_ok = 1'b0; tx_arb_lost = 1'b0;
    endtask

    task automatic expect_quiet(string req);
        bit seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tx_start) seen = 1;
        end
        chk(req, 64'(seen), 64'd0);
    endtask

    function automatic bit prio_less(logic [31:0] a, logic [31:0] b);
        if (a[31:21] != b[31:21]) return a[31:21] < b[31:21];
        if (a[2] != b[2]) return !a[2];
        if (a[2] && a[20:3] != b[20:3]) return a[20:3] < b[20:3];
        return !a[1] && b[1];
    endfunction

    function automatic int model_best();
        int b = -1;
        for (int i = 0; i < NMB; i++)
            if (m_pend[i] && (b < 0 || prio_less(m_id[i], m_id[b]))) b = i;
        return b;
    endfunction

    function automatic int model_worst();
        int w = -1;
        for (int i = 0; i < NMB; i++)
            if (m_pend[i] && (w < 0 || !prio_less(m_id[i], m_id[w]))) w = i;
        return w;
    endfunction

    // Blocker goes first, the other two are armed while it is in flight, the blocker
    // loses arbitration and all three then compete.
    task automatic scenario(string req, int blk, logic [31:0] i0, logic [31:0] i1, logic [31:0] i2);
        int idx;
        logic [31:0] s;
        m_id[0] = i0; m_id[1] = i1; m_id[2] = i2;
        for (int i = 0; i < NMB; i++) m_pend[i] = 0;
        load(blk, m_id[blk], 4'd8, {32'h0, m_id[blk]});
        m_pend[blk] = 1;
        wait_start(req, idx);
        chk(req, 64'(idx), 64'(blk));
        for (int i = 0; i < NMB; i++)
            if (i != blk) begin
                load(i, m_id[i], 4'(i), {m_id[i], 32'hA5A5_0000 | 32'(i)});
                m_pend[i] = 1;
            end
        rd(STAT, s);
        chk("R6 full code", 64'(s[25:24]), 64'(model_worst()));
        finish_tx(1'b0, 1'b1);
        chk("R10 retry pending", 64'(mb_empty[blk]), 64'd0);
        for (int k = 0; k < NMB; k++) begin
            int e;
            e = model_best();
            wait_start(req, idx);
            chk(req, 64'(idx), 64'(e));
            chk({req, " id"}, 64'(tx_id[31:1]), 64'(m_id[e][31:1]));
            finish_tx(1'b1, 1'b0);
            m_pend[e] = 0;
        end
        chk({req, " drained"}, 64'(mb_empty), 64'h7);
    endtask

    function automatic logic [31:0] rnd_id();
        logic [10:0] base = 11'h120 + 11'($urandom_range(0, 3));
        bit ext = $urandom_range(0, 1) == 1;
        bit rtr = $urandom_range(0, 1) == 1;
        logic [17:0] lo = ext ? 18'($urandom_range(0, 2)) : 18'd0;
        return {base, lo, ext, rtr, 1'b0};
    endfunction

    initial begin
        int idx;
        logic [31:0] s;
        void'($urandom(32'h5EED_0147));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(STAT, s);
        chk("R6 reset status", 64'(s), 64'h0004_0404);
        chk("R1 reset idle", 64'({tx_start, busy, mb_empty}), 64'h7);

        // R1 arm and launch, R12 writes while pending ignored
        load(0, {11'h123, 21'd0}, 4'd5, 64'h1122_3344_5566_7788);
        wait_start("R1 launch", idx);
        chk("R1 mbox", 64'(idx), 64'd0);
        chk("R1 fields", {tx_id[31:21], tx_len, 49'd0}, {11'h123, 4'd5, 49'd0});
        chk("R1 data", tx_data, 64'h1122_3344_5566_7788);
        rd(4'd0, s);
        chk("R1 readback", 64'(s), 64'({11'h123, 21'd1}));
        chk("R6 code lowest empty", 64'(next_code), 64'd1);
        wr(4'd0, 32'hFFFF_FFF9);
        wr(4'd1, 32'd2);
        rd(4'd0, s);
        chk("R12 id kept", 64'(s), 64'({11'h123, 21'd1}));
        rd(4'd1, s);
        chk("R12 len kept", 64'(s), 64'd5);
        finish_tx(1'b1, 1'b0);
        rd(STAT, s);
        chk("R7 success flags", 64'(s[7:0]), 64'h07);

        // R11 write-1-to-clear
        wr(STAT, 32'h0);
        rd(STAT, s);
        chk("R11 write 0", 64'(s[0]), 64'd1);
        wr(STAT, 32'h1);
        rd(STAT, s);
        chk("R11 write 1", 64'(s[1:0]), 64'b10);

        // R8 abort of a waiting mailbox
        load(0, {11'h010, 21'd0}, 4'd1, 64'd0);
        wait_start("R8 blocker", idx);
        load(1, {11'h011, 21'd0}, 4'd1, 64'd0);
        wr(STAT, 32'h8000);
        rd(STAT, s);
        chk("R8 cancelled", 64'(s[15:8]), 64'h05);
        finish_tx(1'b1, 1'b0);
        expect_quiet("R8 never sent");

        // R9 abort in flight, success then failure
        load(2, {11'h050, 21'd0}, 4'd1, 64'd0);
        wait_start("R9 launch", idx);
        wr(STAT, 32'h80_0000);
        rd(STAT, s);
        chk("R9 abort pending", 64'({s[23], s[18]}), 64'b10);
        finish_tx(1'b1, 1'b0);
        rd(STAT, s);
        chk("R9 abort lost to success", 64'(s[23:16]), 64'h07);
        load(2, {11'h050, 21'd0}, 4'd1, 64'd0);
        wait_start("R9 launch 2", idx);
        wr(STAT, 32'h80_0000);
        finish_tx(1'b0, 1'b1);
        rd(STAT, s);
        chk("R9 abort on failure", 64'(s[23:16]), 64'h05);
        expect_quiet("R9 no retry");

        // R10 retransmission off then on
        wr(CTRL, 32'd1);
        load(1, {11'h070, 21'd0}, 4'd1, 64'd0);
        wait_start("R10 launch", idx);
        finish_tx(1'b0, 1'b0);
        rd(STAT, s);
        chk("R10 one-shot fail", 64'(s[15:8]), 64'h05);
        expect_quiet("R10 one-shot");
        wr(CTRL, 32'd0);
        load(1, {11'h070, 21'd0}, 4'd1, 64'd0);
        wait_start("R10 launch 2", idx);
        finish_tx(1'b0, 1'b0);
        wait_start("R10 retried", idx);
        chk("R10 retry mbox", 64'(idx), 64'd1);
        finish_tx(1'b1, 1'b0);

        // R13 no pre-emption of the frame in flight
        load(1, {11'h400, 21'd0}, 4'd1, 64'd0);
        wait_start("R13 launch", idx);
        load(0, {11'h001, 21'd0}, 4'd1, 64'd0);
        chk("R13 held", 64'({busy, tx_mbox}), 64'({1'b1, 2'd1}));
        finish_tx(1'b1, 1'b0);
        wait_start("R13 next", idx);
        chk("R13 next mbox", 64'(idx), 64'd0);
        finish_tx(1'b1, 1'b0);

        // Directed priority corners
        scenario("R3 data over remote", 0, {11'h100, 18'd0, 3'b010}, {11'h100, 21'd0}, {11'h200, 21'd0});
        scenario("R4 standard over extended", 1, {11'h050, 18'd0, 3'b100}, {11'h050, 18'd0, 3'b010}, {11'h04F, 18'd7, 3'b100});
        scenario("R5 equal priority index", 2, {11'h300, 21'd0}, {11'h300, 21'd0}, {11'h300, 21'd0});
        scenario("R2 ascending id", 0, {11'h7FF, 21'd0}, {11'h001, 18'd3, 3'b100}, {11'h001, 18'd1, 3'b100});

        for (int t = 0; t < 40; t++)
            scenario("R2 random", $urandom_range(0, 2), rnd_id(), rnd_id(), rnd_id());

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule